// File: doc/BRIEF.md
# Variable-Frequency NCO Clock Generator

This block is a numerically controlled oscillator for one channel. A 16-bit control word sets a phase step that a 16-bit phase register adds on every reference clock cycle while the channel is started. The top bit of the phase register is the variable-frequency square wave. The block also emits a one-cycle tick on every rising edge of that wave. A fixed-frequency duty-cycle stage can use the tick as its timebase.

The control word is treated as a signed quantity. A word with its top bit clear is used as the step directly. A word with its top bit set is replaced by its 16-bit two's complement magnitude. The output frequency is step × 2^-16 × f_ref. The word is loaded as two bytes. The upper byte waits in a holding register and is applied together with the lower byte when the lower byte is written. A half-written word therefore never reaches the phase register.

Top module: `nco_clkgen`

## Requirements
- R1: While `rst_i` is high, and in the first cycle after it falls, `wave_o` and `tick_o` are 0. The applied control word and the holding byte reset to 0.
- R2: While `start_i` is low, the phase register is held at 0. In the cycle after a clock edge with `start_i` low, `wave_o` is 0, so the wave starts low after every restart.
- R3: A write to `cw_wr_hi_i` alone does not change the applied control word. The word becomes {held upper byte, `cw_byte_i`} on the edge where `cw_wr_lo_i` is high. If both strobes are high at the same edge, the lower-byte write uses the upper byte held before that edge.
- R4: When bit 15 of the control word is 1, the step is (65536 − word) mod 65536. For example, 16'hFF00 runs at the same rate as 16'h0100.
- R5: At each edge with `start_i` high, the phase register advances by the step modulo 2^16. `wave_o` is bit 15 of the phase register, so a power-of-two step gives an exact 50% duty cycle with period 65536/step cycles.
- R6: Control word 16'h8000 gives the largest step, 32768. The wave then toggles on every cycle, and this step is the only one with bit 15 set.
- R7: `tick_o` is high for exactly the cycles in which `wave_o` is 1 and was 0 in the previous cycle.
- R8: A newly applied control word changes the step from the next edge on. The phase register is not reset by the load, so the phase carries on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Channel run; low clears the phase |
| cw_wr_hi_i | input | 1 | Stores `cw_byte_i` as the pending upper byte |
| cw_wr_lo_i | input | 1 | Applies {pending upper, `cw_byte_i`} as the control word |
| cw_byte_i | input | 8 | Control word byte |
| wave_o | output | 1 | Variable-frequency square wave (phase MSB) |
| tick_o | output | 1 | One-cycle pulse on each wave rise |

## Verification
A lower-byte write at edge k changes the applied word at edge k. The new step first moves the phase at edge k+1, so its effect shows on `wave_o` after that edge. A change on `start_i` acts on the phase at the next edge, and `tick_o` rises at the same edge as `wave_o`. The bench drives inputs on falling edges and advances its reference model at each rising edge using the inputs seen there. It compares both outputs at the following falling edge, so every check lands one register stage after its stimulus. Counting windows begin at a restart, where the phase is known to be 0, and the expected numbers of high cycles and ticks are worked out from the step alone.

// File: rtl/nco_pkg.sv
package nco_pkg;
  // Magnitude of a signed control word: two's complement when the sign bit is set.
  function automatic logic [15:0] step_of(input logic [15:0] cw);
    return cw[15] ? (~cw + 16'd1) : cw;
  endfunction
endpackage

// File: rtl/nco_cword_latch.sv
module nco_cword_latch #(
  parameter int CW_W = 16,
  localparam int BYTE_W = CW_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [CW_W-1:0]   cword_o
);
  logic [BYTE_W-1:0] pend_hi_q;
  logic [CW_W-1:0]   cword_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pend_hi_q <= '0;
      cword_q   <= '0;
    end else begin
      if (wr_lo_i) cword_q <= {pend_hi_q, byte_i};
      if (wr_hi_i) pend_hi_q <= byte_i;
    end
  end

  assign cword_o = cword_q;

  // R3
  cword_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !wr_lo_i |=> $stable(cword_o));
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
  import nco_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             run_i,
  input  logic [ACC_W-1:0] cword_i,
  output logic             msb_o,
  output logic             msb_next_o
);
  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;

  assign step  = step_of(cword_i);
  assign acc_d = run_i ? acc_q + step : '0;

  always_ff @(posedge clk_i) begin
    if (rst_i) acc_q <= '0;
    else       acc_q <= acc_d;
  end

  assign msb_o      = acc_q[ACC_W-1];
  assign msb_next_o = acc_d[ACC_W-1];

  // R4
  step_magnitude_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    step[ACC_W-1] |-> (step[ACC_W-2:0] == '0));
  // R2
  idle_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_i |=> (acc_q == '0));
endmodule

// File: rtl/nco_rise_tick.sv
module nco_rise_tick (
  input  logic clk_i,
  input  logic rst_i,
  input  logic msb_i,
  input  logic msb_next_i,
  output logic tick_o
);
  logic tick_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) tick_q <= 1'b0;
    else       tick_q <= msb_next_i & ~msb_i;
  end

  assign tick_o = tick_q;

  // R7
  tick_on_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_o |-> (msb_i && !$past(msb_i)));
  // R7
  rise_has_tick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(msb_i) |-> tick_o);
endmodule

// File: rtl/nco_clkgen.sv
module nco_clkgen #(
  parameter int CW_W = 16,
  localparam int BYTE_W = CW_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic              cw_wr_hi_i,
  input  logic              cw_wr_lo_i,
  input  logic [BYTE_W-1:0] cw_byte_i,
  output logic              wave_o,
  output logic              tick_o
);
  logic [CW_W-1:0] cword;
  logic            msb_next;

  nco_cword_latch #(.CW_W(CW_W)) u_latch (
    .clk_i(clk_i), .rst_i(rst_i), .wr_hi_i(cw_wr_hi_i), .wr_lo_i(cw_wr_lo_i),
    .byte_i(cw_byte_i), .cword_o(cword)
  );

  nco_phase_acc #(.ACC_W(CW_W)) u_acc (
    .clk_i(clk_i), .rst_i(rst_i), .run_i(start_i), .cword_i(cword),
    .msb_o(wave_o), .msb_next_o(msb_next)
  );

  nco_rise_tick u_tick (
    .clk_i(clk_i), .rst_i(rst_i), .msb_i(wave_o), .msb_next_i(msb_next),
    .tick_o(tick_o)
  );

  // R2
  restart_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !start_i |=> !wave_o && !tick_o);
endmodule

// File: tb/tb_nco_clkgen.sv
module tb_nco_clkgen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic wr_hi = 1'b0;
  logic wr_lo = 1'b0;
  logic [7:0] wbyte = 8'h00;
  logic wave, tick;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  nco_clkgen dut (
    .clk_i(clk), .rst_i(rst), .start_i(start), .cw_wr_hi_i(wr_hi),
    .cw_wr_lo_i(wr_lo), .cw_byte_i(wbyte), .wave_o(wave), .tick_o(tick)
  );

  // Behavioural reference model
  int m_acc = 0, m_cw = 0, m_hold = 0;
  bit m_tick = 0;
  always @(posedge clk) begin
    int w, nxt;
    cycles++;
    if (rst) begin
      m_acc = 0; m_cw = 0; m_hold = 0; m_tick = 0;
    end else begin
      w = (m_cw >= 32768) ? ((65536 - m_cw) % 65536) : m_cw;
      nxt = start ? ((m_acc + w) % 65536) : 0;
      m_tick = start && (nxt >= 32768) && (m_acc < 32768);
      m_acc = nxt;
      if (wr_lo) m_cw = m_hold * 256 + int'(wbyte);
      if (wr_hi) m_hold = int'(wbyte);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check({cur_req, " wave"}, int'(wave), (m_acc >= 32768) ? 1 : 0);
      check({cur_req, " tick"}, int'(tick), int'(m_tick));
    end
  end

  always @(negedge clk) begin
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic load_word(input logic [15:0] cw);
    @(negedge clk); wr_hi = 1'b1; wbyte = cw[15:8];
    @(negedge clk); wr_hi = 1'b0; wr_lo = 1'b1; wbyte = cw[7:0];
    @(negedge clk); wr_lo = 1'b0;
  endtask

  // Restart from zero phase, then count high samples and ticks over n cycles
  task automatic measure(input int n, output int highs, output int ticks);
    highs = 0; ticks = 0;
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      highs += int'(wave);
      ticks += int'(tick);
    end
  endtask

  initial begin
    int h, t;
    repeat (3) @(negedge clk);
    // R1: outputs low during reset
    check("R1 wave in reset", int'(wave), 0);
    check("R1 tick in reset", int'(tick), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 wave after reset", int'(wave), 0);
    // R1: reset control word is zero, so running does not move the phase
    start = 1'b1;
    repeat (20) @(negedge clk);
    check("R1 idle word keeps wave low", int'(wave), 0);

    cur_req = "R5";
    load_word(16'h0100);
    measure(1024, h, t);
    check("R5 duty 0x0100 highs", h, 512);
    check("R7 ticks 0x0100", t, 4);

    cur_req = "R4";
    load_word(16'hFF00);
    measure(1024, h, t);
    check("R4 negative word highs", h, 512);
    check("R4 negative word ticks", t, 4);

    cur_req = "R6";
    load_word(16'h8000);
    measure(1024, h, t);
    check("R6 max step highs", h, 512);
    check("R6 max step ticks", t, 512);

    cur_req = "R3";
    load_word(16'h0080);
    measure(1024, h, t);
    check("R3 base word ticks", t, 2);
    @(negedge clk); wr_hi = 1'b1; wbyte = 8'h02;
    @(negedge clk); wr_hi = 1'b0;
    measure(1024, h, t);
    check("R3 upper byte alone ignored", t, 2);
    @(negedge clk); wr_lo = 1'b1; wbyte = 8'h00;
    @(negedge clk); wr_lo = 1'b0;
    measure(1024, h, t);
    check("R3 lower byte applies word", t, 8);
    check("R5 duty 0x0200 highs", h, 512);

    // R3: simultaneous strobes use the previously held upper byte (0x02)
    @(negedge clk); wr_hi = 1'b1; wr_lo = 1'b1; wbyte = 8'h00;
    @(negedge clk); wr_hi = 1'b0; wr_lo = 1'b0;
    measure(1024, h, t);
    check("R3 simultaneous strobes", t, 8);

    cur_req = "R8";
    // Change word mid-run: the phase continues without reset
    load_word(16'h0301);
    repeat (300) @(negedge clk);
    load_word(16'hF123);
    repeat (300) @(negedge clk);

    cur_req = "R2";
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    check("R2 wave low after stop", int'(wave), 0);
    repeat (50) @(negedge clk);
    check("R2 wave stays low while stopped", int'(wave), 0);
    check("R2 no tick while stopped", int'(tick), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule